// File: doc/BRIEF.md
# Register-Mapped Serial Peripheral Interface Master

This block is a serial peripheral interface master that software drives through eight 16-bit registers on a simple single-cycle register bus. Software first places up to 32 bits of outgoing data, left-aligned, into the two transmit halves. It then writes one control word. That word carries the transfer length, the target device and the transfer kind (write-only or read-write), and it starts the shift.

The master produces a mode-0 serial clock at the system clock divided by the fixed even factor `DIV`. It drives one active-low chip-select per device and shifts out the most significant bit first. It samples the input line on each rising serial clock edge and assembles the received bits right-aligned in the two receive halves. Completion is reported by one of two status flags: one for write-only transfers and one for read-write transfers. Each flag drives an interrupt line that the matching mask bit in the first setup word can suppress.

Top module: `spi_host_mm`

## Requirements
- R1: After reset, every register reads zero, all chip-selects are high, the serial clock is low and both interrupt lines are low.
- R2: Register offsets on `bus_addr` are 0 setup word A, 1 setup word B, 2 control, 3 status, 4 transmit bits [15:0], 5 transmit bits [31:16], 6 receive bits [15:0], 7 receive bits [31:16]. Setup, control and transmit registers read back the last value stored in them.
- R3: A control write starts a transfer. Control bit 0 requests read-write and bit 1 requests write-only; when both bits are set, read-write is used. Bits [6:2] hold the length minus one, so lengths run from 1 to 32. Bits [9:7] hold the device index. During the transfer only `spi_cs_n[index]` is low.
- R4: Transmit bits leave on `spi_mosi`, starting from bit 31 of {tx high, tx low} and moving downwards, for exactly the programmed length.
- R5: Received bits are right-aligned in {rx high, rx low}. The first bit received lands at position length-1, and all bits above it read zero.
- R6: A started transfer clears both status bits. On completion, status bit 0 (read end) is set for a read-write transfer, or status bit 1 (write end) is set for a write-only one; the two bits are never both set.
- R7: The serial clock idles low, has a period of `DIV` system clocks and is sampled on its rising edge. The chip-select returns high `DIV` system clocks (one serial clock period) after the last falling edge.
- R8: While setup word A bit 0 (clock enable) is clear, a control write is ignored: no chip-select falls and the control readback keeps its old value.
- R9: A control write is ignored if a transfer is in progress, if its device index is `NUM_DEV` or larger, or if neither start bit is set. The ignored write leaves the chip-selects, the status and the control readback unchanged.
- R10: `irq_wr_done` equals status bit 1 AND NOT setup word A bit 4. `irq_rw_done` equals status bit 0 AND NOT setup word A bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | 3 | Register offset (16-bit word index) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_DEV | Active-low chip-select, one per device |
| irq_wr_done | output | 1 | Write-only completion interrupt |
| irq_rw_done | output | 1 | Read-write completion interrupt |

## Verification
The in-RTL assertions check several properties on every cycle: at most one chip-select is low, the serial clock stays low whenever no device is selected, the selected chip-select cannot change in mid-transfer, a start is never accepted while busy, and the two status flags never coexist and one appears after every completion. What only the bench scenarios can show is the data path against an independent slave model. That covers the bit order and the count on the output line, the right-aligned receive word for lengths from 1 to 32, the serial clock period and the chip-select tail measured in time, and the interrupt masking. The bench also confirms at the ports that control writes rejected for a busy transfer, a disabled clock, an out-of-range device or no start bit leave no trace.

// File: rtl/spim_pkg.sv
package spim_pkg;
   localparam int REG_W  = 16;
   localparam int XFER_W = 2 * REG_W;
   localparam int LEN_W  = $clog2(XFER_W);
   localparam int CNT_W  = LEN_W + 1;

   typedef enum logic [2:0] {
      OFS_SETUP_A = 3'd0,
      OFS_SETUP_B = 3'd1,
      OFS_CTRL    = 3'd2,
      OFS_STAT    = 3'd3,
      OFS_TX_LO   = 3'd4,
      OFS_TX_HI   = 3'd5,
      OFS_RX_LO   = 3'd6,
      OFS_RX_HI   = 3'd7
   } reg_ofs_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SHIFT = 2'd1,
      PH_TAIL  = 2'd2
   } phase_e;

   // field positions in the control and setup words
   localparam int CTL_RW     = 0;
   localparam int CTL_WO     = 1;
   localparam int CTL_LEN_LO = 2;
   localparam int CTL_DEV_LO = 7;
   localparam int SUA_CLKEN  = 0;
   localparam int SUA_WMASK  = 4;
   localparam int SUA_RMASK  = 5;
   localparam int ST_RDEND   = 0;
   localparam int ST_WREND   = 1;
endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int HALF = DIV / 2;

   generate
      if (HALF == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(HALF);
         localparam logic [CW-1:0] LAST = CW'(HALF - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt_q <= '0;
            else if (!run)         cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
         end
         assign tick = run && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
   import spim_pkg::*;
#(
   parameter int NUM_DEV = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [CNT_W-1:0]    start_len,
   input  logic [2:0]          start_dev,
   input  logic [XFER_W-1:0]   tx_word,
   input  logic                tick,
   input  logic                miso,
   output logic                busy,
   output logic                done,
   output logic                sclk,
   output logic                mosi,
   output logic [NUM_DEV-1:0]  cs_n,
   output logic [XFER_W-1:0]   rx_word
);
   localparam logic [NUM_DEV-1:0] DEV_ONE = NUM_DEV'(1);
   localparam logic [CNT_W-1:0]   LEN_ONE = CNT_W'(1);

   phase_e              phase_q;
   logic                sclk_q, tail_q, done_q;
   logic [CNT_W-1:0]    left_q;
   logic [XFER_W-1:0]   tx_sr, rx_sr;
   logic [NUM_DEV-1:0]  cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         sclk_q  <= 1'b0;
         tail_q  <= 1'b0;
         done_q  <= 1'b0;
         left_q  <= '0;
         tx_sr   <= '0;
         rx_sr   <= '0;
         cs_q    <= '1;
      end else begin
         done_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: if (start) begin
               phase_q <= PH_SHIFT;
               tx_sr   <= tx_word;
               rx_sr   <= '0;
               left_q  <= start_len;
               cs_q    <= ~(DEV_ONE << start_dev);
               sclk_q  <= 1'b0;
            end
            PH_SHIFT: if (tick) begin
               if (!sclk_q) begin
                  sclk_q <= 1'b1;
                  rx_sr  <= {rx_sr[XFER_W-2:0], miso};
               end else begin
                  sclk_q <= 1'b0;
                  tx_sr  <= {tx_sr[XFER_W-2:0], 1'b0};
                  if (left_q == LEN_ONE) begin
                     phase_q <= PH_TAIL;
                     tail_q  <= 1'b0;
                  end else begin
                     left_q <= left_q - 1'b1;
                  end
               end
            end
            PH_TAIL: if (tick) begin
               if (tail_q) begin
                  phase_q <= PH_IDLE;
                  cs_q    <= '1;
                  done_q  <= 1'b1;
               end else begin
                  tail_q <= 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign busy    = (phase_q != PH_IDLE);
   assign done    = done_q;
   assign sclk    = sclk_q;
   assign mosi    = tx_sr[XFER_W-1];
   assign cs_n    = cs_q;
   assign rx_word = rx_sr;

   AST_CS_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cs_n) <= 1); // R3
   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (&cs_n) |-> !sclk); // R7
   AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(cs_n) || (&cs_n))); // R7
   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (phase_q == PH_IDLE)); // R9
endmodule

// File: rtl/spim_regs.sv
module spim_regs
   import spim_pkg::*;
#(
   parameter int NUM_DEV = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_we,
   input  logic [2:0]         bus_addr,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   input  logic               busy,
   input  logic               done,
   input  logic [XFER_W-1:0]  rx_word,
   output logic               start,
   output logic [CNT_W-1:0]   start_len,
   output logic [2:0]         start_dev,
   output logic [XFER_W-1:0]  tx_word,
   output logic               irq_wr_done,
   output logic               irq_rw_done
);
   localparam logic [2:0] DEV_MAX = 3'(NUM_DEV - 1);

   logic [REG_W-1:0] sua_q, sub_q, ctl_q, txlo_q, txhi_q;
   logic [1:0]       stat_q;
   logic             wr, ctl_wr, kind_ok;

   assign wr        = bus_sel && bus_we;
   assign ctl_wr    = wr && (reg_ofs_e'(bus_addr) == OFS_CTRL);
   assign start_dev = bus_wdata[CTL_DEV_LO +: 3];
   assign kind_ok   = bus_wdata[CTL_RW] || bus_wdata[CTL_WO];
   assign start     = ctl_wr && !busy && sua_q[SUA_CLKEN] && kind_ok
                      && (start_dev <= DEV_MAX);
   assign start_len = {1'b0, bus_wdata[CTL_LEN_LO +: LEN_W]} + 1'b1;
   assign tx_word   = {txhi_q, txlo_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sua_q  <= '0;
         sub_q  <= '0;
         ctl_q  <= '0;
         txlo_q <= '0;
         txhi_q <= '0;
         stat_q <= '0;
      end else begin
         if (wr) begin
            unique case (reg_ofs_e'(bus_addr))
               OFS_SETUP_A: sua_q  <= bus_wdata;
               OFS_SETUP_B: sub_q  <= bus_wdata;
               OFS_TX_LO:   txlo_q <= bus_wdata;
               OFS_TX_HI:   txhi_q <= bus_wdata;
               default: ;
            endcase
         end
         if (start) begin
            ctl_q  <= bus_wdata;
            stat_q <= '0;
         end else if (done) begin
            if (ctl_q[CTL_RW]) stat_q[ST_RDEND] <= 1'b1;
            else               stat_q[ST_WREND] <= 1'b1;
         end
      end
   end

   always_comb begin
      unique case (reg_ofs_e'(bus_addr))
         OFS_SETUP_A: bus_rdata = sua_q;
         OFS_SETUP_B: bus_rdata = sub_q;
         OFS_CTRL:    bus_rdata = ctl_q;
         OFS_STAT:    bus_rdata = {{(REG_W-2){1'b0}}, stat_q};
         OFS_TX_LO:   bus_rdata = txlo_q;
         OFS_TX_HI:   bus_rdata = txhi_q;
         OFS_RX_LO:   bus_rdata = rx_word[REG_W-1:0];
         default:     bus_rdata = rx_word[XFER_W-1:REG_W];
      endcase
   end

   assign irq_wr_done = stat_q[ST_WREND] && !sua_q[SUA_WMASK];
   assign irq_rw_done = stat_q[ST_RDEND] && !sua_q[SUA_RMASK];

   AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat_q[ST_RDEND] && stat_q[ST_WREND])); // R6
   AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (stat_q != 2'b00)); // R6
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && stat_q == 2'b00)); // R6
endmodule

// File: rtl/spi_host_mm.sv
module spi_host_mm
   import spim_pkg::*;
#(
   parameter int DIV     = 4,
   parameter int NUM_DEV = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_we,
   input  logic [2:0]         bus_addr,
   input  logic [15:0]        bus_wdata,
   output logic [15:0]        bus_rdata,
   output logic               spi_sclk,
   output logic               spi_mosi,
   input  logic               spi_miso,
   output logic [NUM_DEV-1:0] spi_cs_n,
   output logic               irq_wr_done,
   output logic               irq_rw_done
);
   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("DIV must be an even value of at least 2");
      end
      if (NUM_DEV < 1 || NUM_DEV > 8) begin : g_bad_dev
         $error("NUM_DEV must lie in 1..8 (3-bit device field)");
      end
   endgenerate

   logic              start, busy, done, tick;
   logic [CNT_W-1:0]  start_len;
   logic [2:0]        start_dev;
   logic [XFER_W-1:0] tx_word, rx_word;

   spim_regs #(.NUM_DEV(NUM_DEV)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy), .done(done), .rx_word(rx_word),
      .start(start), .start_len(start_len), .start_dev(start_dev),
      .tx_word(tx_word),
      .irq_wr_done(irq_wr_done), .irq_rw_done(irq_rw_done)
   );

   spim_clkgen #(.DIV(DIV)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
   );

   spim_shifter #(.NUM_DEV(NUM_DEV)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .start(start), .start_len(start_len), .start_dev(start_dev),
      .tx_word(tx_word), .tick(tick), .miso(spi_miso),
      .busy(busy), .done(done), .sclk(spi_sclk), .mosi(spi_mosi),
      .cs_n(spi_cs_n), .rx_word(rx_word)
   );
endmodule

// File: tb/spi_host_mm_tb.sv
`timescale 1ns/1ps
module spi_host_mm_tb;
   localparam int DIV = 4;
   localparam int ND  = 5;
   localparam logic [2:0] A_SUA = 3'd0, A_SUB = 3'd1, A_CTL = 3'd2, A_STAT = 3'd3,
                          A_TXLO = 3'd4, A_TXHI = 3'd5, A_RXLO = 3'd6, A_RXHI = 3'd7;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_sel = 1'b0, bus_we = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0, bus_rdata;
   logic spi_sclk, spi_mosi, spi_miso = 1'b0;
   logic [ND-1:0] spi_cs_n;
   logic irq_wr_done, irq_rw_done;

   int checks = 0, fails = 0, cyc = 0;
   logic [31:0] slave_pat = '0, sreg = '0, cap = '0;
   logic [15:0] cur_sua = '0, last_ctl = '0;
   realtime t_fall = 0, t_rise = 0, tail_ns = 0, period_ns = 0;
   logic cs_all;

   spi_host_mm #(.DIV(DIV), .NUM_DEV(ND)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_cs_n(spi_cs_n), .irq_wr_done(irq_wr_done), .irq_rw_done(irq_rw_done)
   );

   always #2.5 clk = ~clk;
   assign cs_all = &spi_cs_n;

   // slave model: mode 0, presents next bit after each falling edge
   always @(negedge cs_all) begin
      sreg = slave_pat; spi_miso = sreg[31]; cap = '0;
   end
   always @(negedge spi_sclk) begin
      t_fall = $realtime;
      if (!cs_all) begin sreg = sreg << 1; spi_miso = sreg[31]; end
   end
   always @(posedge spi_sclk) begin
      if (t_rise > 0) period_ns = $realtime - t_rise;
      t_rise = $realtime;
      cap = {cap[30:0], spi_mosi};
   end
   always @(posedge cs_all) tail_ns = $realtime - t_fall;

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not complete (act=%0d exp<150000)", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
      if (a == A_SUA) cur_sua = d;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_done(output logic [15:0] st);
      st = '0;
      for (int i = 0; i < 3000 && st == 16'h0; i++) rd(A_STAT, st);
   endtask

   function automatic logic [15:0] mk_ctl(input int len, input int dev, input bit rw);
      return 16'(((dev & 7) << 7) | (((len - 1) & 31) << 2) | (rw ? 1 : 2));
   endfunction

   task automatic xfer(input int len, input int dev, input bit rw,
                       input logic [31:0] tx, input logic [31:0] pat);
      logic [15:0] st, lo, hi;
      logic [31:0] mask, exp_tx, exp_rx;
      logic [ND-1:0] exp_cs;
      slave_pat = pat;
      wr(A_TXLO, tx[15:0]);
      wr(A_TXHI, tx[31:16]);
      last_ctl = mk_ctl(len, dev, rw);
      wr(A_CTL, last_ctl);
      rd(A_STAT, st);
      chk(st == 16'h0, "R6 status cleared at start", 32'(st), 32'h0);
      exp_cs = ~(ND'(1) << dev);
      chk(spi_cs_n == exp_cs, "R3 only selected chip-select low", 32'(spi_cs_n), 32'(exp_cs));
      wait_done(st);
      mask   = (len == 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 1);
      exp_tx = tx >> (32 - len);
      exp_rx = pat >> (32 - len);
      rd(A_RXLO, lo); rd(A_RXHI, hi);
      chk({hi, lo} == exp_rx, "R5 right-aligned receive word", {hi, lo}, exp_rx);
      chk((cap & mask) == exp_tx, "R4 MSB-first transmit bits", cap & mask, exp_tx);
      chk(st == (rw ? 16'h1 : 16'h2), "R6 completion flag", 32'(st), rw ? 32'h1 : 32'h2);
      chk(tail_ns > DIV * 5.0 - 0.1 && tail_ns < DIV * 5.0 + 0.1,
          "R7 chip-select tail", 32'(int'(tail_ns * 10)), 32'(DIV * 50));
      chk(irq_wr_done == (!rw && !cur_sua[4]) && irq_rw_done == (rw && !cur_sua[5]),
          "R10 interrupt lines", {30'b0, irq_wr_done, irq_rw_done},
          {30'b0, !rw && !cur_sua[4], rw && !cur_sua[5]});
   endtask

   initial begin
      logic [15:0] v;
      logic [ND-1:0] cs_snap;
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(spi_cs_n == '1 && spi_sclk == 1'b0 && !irq_wr_done && !irq_rw_done,
          "R1 pins at reset", {spi_cs_n, spi_sclk, irq_wr_done, irq_rw_done}, {5'h1f, 3'b000});
      rst_n = 1'b1;
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v);
         chk(v == 16'h0, "R1 register zero after reset", 32'(v), 32'h0);
      end
      // R2 offsets and readback
      wr(A_SUB, 16'hA5C3); rd(A_SUB, v);
      chk(v == 16'hA5C3, "R2 setup word B readback", 32'(v), 32'hA5C3);
      wr(A_TXLO, 16'h1357); wr(A_TXHI, 16'h9BDF);
      rd(A_TXLO, v); chk(v == 16'h1357, "R2 tx low readback", 32'(v), 32'h1357);
      rd(A_TXHI, v); chk(v == 16'h9BDF, "R2 tx high readback", 32'(v), 32'h9BDF);
      // R8 clock enable clear: control write ignored
      wr(A_CTL, mk_ctl(8, 1, 1'b0));
      repeat (20) @(negedge clk);
      chk(cs_all && !spi_sclk, "R8 no transfer without clock enable", 32'(spi_cs_n), 32'h1f);
      rd(A_CTL, v); chk(v == 16'h0, "R8 control readback unchanged", 32'(v), 32'h0);
      wr(A_SUA, 16'h0001);
      rd(A_SUA, v); chk(v == 16'h0001, "R2 setup word A readback", 32'(v), 32'h1);
      // directed corners
      xfer(1, 0, 1'b1, 32'h8000_0000, 32'h8000_0000);
      xfer(32, 4, 1'b0, 32'hC3A5_0F96, 32'h5A5A_F00F);
      chk(period_ns > DIV * 5.0 - 0.1 && period_ns < DIV * 5.0 + 0.1,
          "R7 serial clock period", 32'(int'(period_ns * 10)), 32'(DIV * 50));
      xfer(32, 3, 1'b1, 32'h0123_4567, 32'hFEDC_BA98);
      xfer(17, 2, 1'b1, 32'hFFFF_8000, 32'h8000_FFFF);
      // R3 both start bits set -> read-write
      slave_pat = 32'hF000_0000;
      last_ctl = 16'(mk_ctl(4, 1, 1'b1) | 16'h2);
      wr(A_CTL, last_ctl);
      wait_done(v);
      chk(v == 16'h1, "R3 both start bits select read-write", 32'(v), 32'h1);
      // R9 invalid device index
      wr(A_CTL, mk_ctl(8, 5, 1'b0));
      repeat (10) @(negedge clk);
      chk(cs_all, "R9 device index 5 ignored", 32'(spi_cs_n), 32'h1f);
      rd(A_STAT, v); chk(v == 16'h1, "R9 status untouched by invalid index", 32'(v), 32'h1);
      rd(A_CTL, v); chk(v == last_ctl, "R9 control kept after invalid index", 32'(v), 32'(last_ctl));
      // R9 neither start bit
      wr(A_CTL, 16'((2 << 7) | (7 << 2)));
      repeat (10) @(negedge clk);
      chk(cs_all, "R9 no start bit ignored", 32'(spi_cs_n), 32'h1f);
      rd(A_CTL, v); chk(v == last_ctl, "R9 control kept after no-start write", 32'(v), 32'(last_ctl));
      // R9 write while busy
      wr(A_TXLO, 16'h0); wr(A_TXHI, 16'hFFFF);
      last_ctl = mk_ctl(32, 2, 1'b0);
      wr(A_CTL, last_ctl);
      repeat (10) @(negedge clk);
      cs_snap = spi_cs_n;
      wr(A_CTL, mk_ctl(8, 0, 1'b1));
      rd(A_CTL, v); chk(v == last_ctl, "R9 busy control write ignored", 32'(v), 32'(last_ctl));
      chk(spi_cs_n == cs_snap, "R9 chip-select kept during busy write", 32'(spi_cs_n), 32'(cs_snap));
      wait_done(v);
      chk(v == 16'h2, "R9 ignored write did not change mode", 32'(v), 32'h2);
      // R10 masks
      wr(A_SUA, 16'h0011);
      xfer(9, 1, 1'b0, 32'hAAAA_0000, 32'h5555_0000);
      wr(A_SUA, 16'h0021);
      xfer(9, 0, 1'b1, 32'h1234_0000, 32'hBEEF_0000);
      wr(A_SUA, 16'h0001);
      // constrained random
      for (int n = 0; n < 30; n++) begin
         xfer(int'($urandom_range(32, 1)), int'($urandom_range(ND - 1, 0)),
              1'($urandom_range(1, 0)), $urandom, $urandom);
      end
      summary();
      $finish;
   end
endmodule